// File: doc/BRIEF.md
# Serial Word Receiver with Selectable Bit Order and Justification

This block takes a 16-bit serial frame from an external source and recovers the 14-bit code held in it, ready for an input latch. The serial clock, the serial data and a frame-sync line arrive asynchronously. All three are synchronised to a faster system clock, and the serial clock's falling edges are found from the synchronised samples. A rising edge on the synchronised frame sync opens a frame. The next 16 falling serial-clock edges each shift in one data bit.

Two static mode inputs, `fmt_i` and `jst_i`, pick one of four mappings from bit position to word position. They set whether the code arrives LSB-first or MSB-first, and whether the two unused bits come first or last in the frame. The mode is captured when the frame opens. Once the last bit has arrived, the block presents the word on `word_o` together with a one-cycle `vld_o` strobe. The word is held until the next complete frame.

Top module: `ser_word_rx`

## Requirements
- R1: While the reset is active and right after it, `vld_o` is 0 and `word_o` is all zeros.
- R2: The frame starts at a rising edge of `fsync_i`. Exactly 16 falling edges of `sclk_i` follow it. Counting from the system clock rising edge that first samples `sclk_i` low after the 16th fall, `vld_o` is high after the 4th rising edge and low after the 3rd (SYNC_STAGES + 2 edges, default 2 + 2).
- R3: With `fmt_i`=0 and `jst_i`=0, serial bits 1 and 2 are discarded. Bit 3 becomes `word_o[0]` and bit 16 becomes `word_o[13]`.
- R4: With `fmt_i`=0 and `jst_i`=1, bit 1 becomes `word_o[0]` and bit 14 becomes `word_o[13]`. Bits 15 and 16 are discarded.
- R5: With `fmt_i`=1 and `jst_i`=0, bits 1 and 2 are discarded. Bit 3 becomes `word_o[13]` and bit 16 becomes `word_o[0]`.
- R6: With `fmt_i`=1 and `jst_i`=1, bit 1 becomes `word_o[13]` and bit 14 becomes `word_o[0]`. Bits 15 and 16 are discarded.
- R7: The mode is taken at the start of the frame. Changing `fmt_i` or `jst_i` during the frame does not change the mapping of that frame.
- R8: A new frame-sync rising edge in the middle of a frame discards the bits received so far. The bit count then starts again from one, with the newly sampled mode.
- R9: `vld_o` is high for exactly one system clock cycle per completed frame.
- R10: Falling serial-clock edges after a completed frame, with no new frame sync, produce no strobe and leave `word_o` unchanged.
- R11: `word_o` keeps its value between strobes and changes only in the cycle where `vld_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sclk_i | input | 1 | Serial clock, idles high, data taken on falling edges |
| sdat_i | input | 1 | Serial data |
| fsync_i | input | 1 | Frame sync, a rising edge opens a frame |
| fmt_i | input | 1 | Bit order select: 0 LSB-first, 1 MSB-first |
| jst_i | input | 1 | Justify select: 0 unused bits lead, 1 unused bits trail |
| word_o | output | 14 | Recovered code |
| vld_o | output | 1 | One-cycle strobe marking a new `word_o` |

## Verification
The only timed result is the strobe and the word that comes with it. Both are due on the fourth system rising edge after the edge that first sees the 16th serial-clock fall. That is two synchroniser stages, one edge-detect and shift register, and one output register. The bench drives every input on the falling system clock edge. It checks at that same phase: the strobe is low one cycle early, the strobe and word are correct at the due cycle, and the strobe is low again one cycle later. For the restart and ignored-edge cases, a running count of strobes and the held word are compared after enough cycles for any stray strobe to have appeared.

// File: rtl/swr_pkg.sv
package swr_pkg;

  // {fmt, jst}: fmt selects MSB-first, jst puts the code at the head of the frame
  typedef enum logic [1:0] {
    ORD_LSB_TAIL = 2'b00,
    ORD_LSB_HEAD = 2'b01,
    ORD_MSB_TAIL = 2'b10,
    ORD_MSB_HEAD = 2'b11
  } swr_order_e;

endpackage

// File: rtl/swr_rst_sync.sv
module swr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = chain_q[STAGES-1];

endmodule

// File: rtl/swr_sync.sv
module swr_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  localparam int CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], d_i};
  end

  assign q_o = chain_q[CHAIN_W-1 -: WIDTH];

endmodule

// File: rtl/swr_frame.sv
module swr_frame #(
  parameter int FRAME_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk_s,
  input  logic                  sdat_s,
  input  logic                  fsync_s,
  input  logic [1:0]            mode_i,
  output logic [FRAME_BITS-1:0] bits_o,
  output logic [1:0]            mode_o,
  output logic                  done_o
);

  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);

  logic                  sclk_d_q, fsync_d_q;
  logic                  act_q, act_n;
  logic [CNT_W-1:0]      cnt_q, cnt_n;
  logic [FRAME_BITS-1:0] sh_q, sh_n;
  logic [1:0]            mode_q, mode_n;
  logic                  done_q, done_n;
  logic                  fall, start, shift, last, sh_en;

  // next-state logic
  always_comb begin
    fall   = sclk_d_q & ~sclk_s;
    start  = fsync_s & ~fsync_d_q;
    shift  = fall & act_q & ~start;
    last   = shift && (cnt_q == LAST_IDX);
    sh_en  = start | shift;
    act_n  = act_q;
    cnt_n  = cnt_q;
    sh_n   = sh_q;
    mode_n = mode_q;
    if (start) begin
      act_n  = 1'b1;
      cnt_n  = '0;
      sh_n   = '0;
      mode_n = mode_i;
    end else if (shift) begin
      cnt_n = cnt_q + 1'b1;
      sh_n  = {sh_q[FRAME_BITS-2:0], sdat_s};
      if (last) act_n = 1'b0;
    end
    done_n = last;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q  <= 1'b1;
      fsync_d_q <= 1'b0;
      act_q     <= 1'b0;
      cnt_q     <= '0;
      sh_q      <= '0;
      mode_q    <= '0;
      done_q    <= 1'b0;
    end else begin
      sclk_d_q  <= sclk_s;
      fsync_d_q <= fsync_s;
      done_q    <= done_n;
      if (sh_en) begin
        act_q <= act_n;
        cnt_q <= cnt_n;
        sh_q  <= sh_n;
      end
      if (start) mode_q <= mode_n;
    end
  end

  assign bits_o = sh_q;
  assign mode_o = mode_q;
  assign done_o = done_q;

  // R8: a frame sync restarts the count at zero in an open frame
  a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (act_q && cnt_q == '0));

  // R7: captured mode does not move while a frame runs
  a_r7_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !start) |=> $stable(mode_q));

  // R2: the completion pulse closes the frame
  a_r2_done_closes: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !act_q);

  // R10: with no open frame, serial edges do not move the shift register
  a_r10_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && !start) |=> $stable(sh_q));

endmodule

// File: rtl/swr_map.sv
module swr_map
  import swr_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int WORD_BITS  = 14
) (
  input  logic [FRAME_BITS-1:0] bits_i,
  input  logic [1:0]            mode_i,
  output logic [WORD_BITS-1:0]  word_o
);

  localparam int PAD = FRAME_BITS - WORD_BITS;

  // bits_i[FRAME_BITS-1] holds the first serial bit, bits_i[0] the last
  logic [WORD_BITS-1:0] lsb_tail, lsb_head, msb_tail, msb_head;

  assign msb_tail = bits_i[WORD_BITS-1:0];
  assign msb_head = bits_i[FRAME_BITS-1:PAD];

  for (genvar j = 0; j < WORD_BITS; j++) begin : g_rev
    assign lsb_tail[j] = bits_i[WORD_BITS-1-j];
    assign lsb_head[j] = bits_i[FRAME_BITS-1-j];
  end

  always_comb begin
    unique case (swr_order_e'(mode_i))
      ORD_LSB_TAIL: word_o = lsb_tail;
      ORD_LSB_HEAD: word_o = lsb_head;
      ORD_MSB_TAIL: word_o = msb_tail;
      default:      word_o = msb_head;
    endcase
  end

endmodule

// File: rtl/ser_word_rx.sv
module ser_word_rx #(
  parameter int FRAME_BITS  = 16,
  parameter int WORD_BITS   = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk_i,
  input  logic                 sdat_i,
  input  logic                 fsync_i,
  input  logic                 fmt_i,
  input  logic                 jst_i,
  output logic [WORD_BITS-1:0] word_o,
  output logic                 vld_o
);

  localparam int IN_W = 3;
  localparam logic [IN_W-1:0] IN_RST = 3'b100; // serial clock idles high

  logic                  rst_sn;
  logic [IN_W-1:0]       in_s;
  logic [FRAME_BITS-1:0] bits;
  logic [1:0]            mode_cap;
  logic                  done;
  logic [WORD_BITS-1:0]  word_map, word_q, word_n;
  logic                  vld_q;

  swr_rst_sync #(.STAGES(SYNC_STAGES)) i_rst (
    .clk(clk), .arst_n(rst_n), .rst_sn(rst_sn)
  );

  swr_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) i_sync (
    .clk(clk), .rst_n(rst_sn),
    .d_i({sclk_i, sdat_i, fsync_i}), .q_o(in_s)
  );

  swr_frame #(.FRAME_BITS(FRAME_BITS)) i_frame (
    .clk(clk), .rst_n(rst_sn),
    .sclk_s(in_s[2]), .sdat_s(in_s[1]), .fsync_s(in_s[0]),
    .mode_i({fmt_i, jst_i}),
    .bits_o(bits), .mode_o(mode_cap), .done_o(done)
  );

  swr_map #(.FRAME_BITS(FRAME_BITS), .WORD_BITS(WORD_BITS)) i_map (
    .bits_i(bits), .mode_i(mode_cap), .word_o(word_map)
  );

  always_comb begin
    word_n = done ? word_map : word_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= done;
      if (done) word_q <= word_n;
    end
  end

  assign word_o = word_q;
  assign vld_o  = vld_q;

  // R1: outputs idle while reset is held
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_sn |-> (!vld_o && word_o == '0));

  // R9: strobe lasts a single cycle
  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_sn)
    vld_o |=> !vld_o);

  // R2: every completed frame yields a strobe on the next edge
  a_r2_strobe_follows: assert property (@(posedge clk) disable iff (!rst_sn)
    done |=> vld_o);

  // R11: the word moves only together with the strobe
  a_r11_word_held: assert property (@(posedge clk) disable iff (!rst_sn)
    !$stable(word_o) |-> vld_o);

endmodule

// File: tb/test_ser_word_rx.sv
module test_ser_word_rx;

  localparam int FB   = 16;
  localparam int WB   = 14;
  localparam int SS   = 2;
  localparam int LAT  = SS + 2;
  localparam int HALF = 3;
  localparam int NVEC = 8;

  localparam logic [FB-1:0] TV_FRAME [NVEC] = '{
    16'hA5C3, 16'h3FFF, 16'hC000, 16'h0001,
    16'h8000, 16'h7FFE, 16'h1234, 16'hFFFF
  };
  localparam logic [1:0] TV_MODE [NVEC] = '{
    2'b00, 2'b01, 2'b10, 2'b11,
    2'b00, 2'b01, 2'b10, 2'b11
  };

  logic          clk = 1'b0;
  logic          rst_n, sclk_i, sdat_i, fsync_i, fmt_i, jst_i;
  logic [WB-1:0] word_o;
  logic          vld_o;

  int checks = 0, errors = 0, vld_seen = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ser_word_rx i_ser_word_rx (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .sdat_i(sdat_i),
    .fsync_i(fsync_i), .fmt_i(fmt_i), .jst_i(jst_i),
    .word_o(word_o), .vld_o(vld_o)
  );

  always @(negedge clk) if (vld_o === 1'b1) vld_seen++;

  // serial bit n (1 = first sent) sits at frame[FB-n]
  function automatic logic bitn(logic [FB-1:0] f, int n);
    return f[FB-n];
  endfunction

  function automatic logic [WB-1:0] expect_word(logic [FB-1:0] f, logic [1:0] m);
    logic [WB-1:0] w;
    for (int j = 0; j < WB; j++) begin
      case (m)
        2'b00: w[j]      = bitn(f, 3 + j);
        2'b01: w[j]      = bitn(f, 1 + j);
        2'b10: w[WB-1-j] = bitn(f, 3 + j);
        default: w[WB-1-j] = bitn(f, 1 + j);
      endcase
    end
    return w;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic begin_frame(logic [1:0] m);
    fmt_i = m[1]; jst_i = m[0]; fsync_i = 1'b1;
    tick(HALF);
    fsync_i = 1'b0;
    tick(HALF);
  endtask

  task automatic pulse_bit(logic b);
    sdat_i = b;
    tick(HALF);
    sclk_i = 1'b0;
    tick(HALF);
    sclk_i = 1'b1;
  endtask

  task automatic last_bit(logic b, logic [WB-1:0] exp, string tag);
    sdat_i = b;
    tick(HALF);
    sclk_i = 1'b0;
    tick(LAT - 1);
    check(vld_o == 1'b0, $sformatf("%s R2 strobe early", tag), 32'(vld_o), 0);
    tick(1);
    check(vld_o == 1'b1, $sformatf("%s R2 strobe due", tag), 32'(vld_o), 1);
    check(word_o == exp, $sformatf("%s word", tag), 32'(word_o), 32'(exp));
    tick(1);
    check(vld_o == 1'b0, $sformatf("%s R9 strobe width", tag), 32'(vld_o), 0);
    sclk_i = 1'b1;
    tick(HALF);
  endtask

  task automatic send_frame(logic [FB-1:0] f, logic [1:0] m, string tag);
    begin_frame(m);
    for (int i = 1; i < FB; i++) pulse_bit(bitn(f, i));
    last_bit(bitn(f, FB), expect_word(f, m), tag);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 50000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [WB-1:0] held;
    int base;
    rst_n = 1'b0; sclk_i = 1'b1; sdat_i = 1'b0; fsync_i = 1'b0;
    fmt_i = 1'b0; jst_i = 1'b0;
    tick(3);
    check(vld_o == 1'b0 && word_o == '0, "R1 in reset", 32'(word_o), 0);
    rst_n = 1'b1;
    tick(5);
    check(vld_o == 1'b0 && word_o == '0, "R1 after reset", 32'(word_o), 0);

    // table of vectors: R3 (00), R4 (01), R5 (10), R6 (11)
    for (int v = 0; v < NVEC; v++) begin
      base = vld_seen;
      send_frame(TV_FRAME[v], TV_MODE[v],
                 $sformatf("vec%0d R%0d", v, 3 + int'(TV_MODE[v])));
      check(vld_seen == base + 1, "R9 one strobe per frame", 32'(vld_seen - base), 1);
    end

    // R7: mode changed mid-frame is ignored
    begin_frame(2'b10);
    for (int i = 1; i <= 5; i++) pulse_bit(bitn(16'h5A3C, i));
    fmt_i = 1'b0; jst_i = 1'b1;
    for (int i = 6; i < FB; i++) pulse_bit(bitn(16'h5A3C, i));
    last_bit(bitn(16'h5A3C, FB), expect_word(16'h5A3C, 2'b10), "R7 mode latch");

    // R8 and R11: restart mid-frame discards partial bits
    held = word_o;
    base = vld_seen;
    begin_frame(2'b00);
    for (int i = 0; i < 7; i++) pulse_bit(1'b1);
    tick(LAT + 2);
    check(word_o == held, "R11 word held mid-frame", 32'(word_o), 32'(held));
    send_frame(16'h0F0F, 2'b11, "R8 restart");
    check(vld_seen == base + 1, "R8 single strobe after restart", 32'(vld_seen - base), 1);

    // R10: serial edges with no frame sync are ignored
    held = word_o;
    base = vld_seen;
    for (int i = 0; i < FB + 4; i++) pulse_bit(i[0]);
    tick(LAT + 2);
    check(vld_seen == base, "R10 no strobe", 32'(vld_seen - base), 0);
    check(word_o == held, "R10 word unchanged", 32'(word_o), 32'(held));

    // R4 again after idle edges: receiver still frames correctly
    send_frame(16'hBEEF, 2'b01, "R4 after idle");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule